// File: doc/BRIEF.md
# Timed Pin Timestamp Unit

This block timestamps events on a single pin, for time synchronisation. It sits beside a free-running timer that is never stopped and receives the timer's current value on every clock. It either watches the pin or drives it, and software chooses which.

In capture mode it synchronises the pin and filters it, so that a high level must be seen on two consecutive clocks before it counts as an event. Each event stores the timer value in a capture register. In generate mode it compares the timer with a target that software writes. On a match it drives a pulse of fixed width on the pin and stores the timer value. With repetition on, it advances the target by an interval after each match. A counter numbers the events. Reading the capture register copies that counter into a snapshot register, so software can pair a time with an event number. A status flag reports a fresh capture. An overrun flag reports a capture that arrived before the previous one was read.

Top module: `tgpio_stamp`

## Requirements
- R1: After reset, `pin_out` and `pin_oe` are 0 and every register reads 0. The register addresses are: 0 control/status, 1 target, 2 interval, 3 capture, 4 counter snapshot.
- R2: In capture mode (control bit0 = 1 enable, bit1 = 0), a qualified pin event stores the timer value seen at the third rising clock edge after the first edge that samples the pin high.
- R3: A high level on `pin_in` sampled by only one clock edge produces no event. A longer high level produces exactly one event.
- R4: In generate mode (control bit0 = 1, bit1 = 1), a clock edge at which the timer equals an armed target stores that timer value and drives `pin_out` high for exactly the following 2 clock cycles. Writing the target arms it. With repetition off (control bit2 = 0), the target then disarms.
- R5: With repetition on (control bit2 = 1) and a nonzero interval, each match adds the interval to the target, so pulses repeat every interval cycles. An interval of 0 gives a single match only.
- R6: The event counter rises by one per event in either mode. A read of the capture register copies the counter value into the snapshot register at address 4.
- R7: Control bit3 (status) sets on each capture and clears when the capture register is read. Control bit4 (overrun) sets when a capture arrives while status is set. Overrun stays set until a control write with bit4 = 1 clears it.
- R8: While bit0 is 0, the pin causes no event and the event counter is held at 0. Clearing bit0 also ends any pulse at once. `pin_oe` equals bit0 AND bit1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the free-running timer advances on the same clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timer | input | TW | Current value of the free-running timer |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects for the capture address) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | TW | Write data |
| reg_rdata | output | TW | Read data, combinational from the address |
| pin_in | input | 1 | Pin level in capture mode (asynchronous) |
| pin_out | output | 1 | Pin level driven in generate mode |
| pin_oe | output | 1 | Pin drive enable |

## Verification
The assertions assume that the read and write strobes never target the same register in the same cycle. They also assume that the timer changes only on clock edges, so a match is seen at a single edge. The stimulus advances the timer by one on every rising edge and changes pins and strobes only on falling edges. Each register access lasts exactly one cycle. Targets are always placed well ahead of the current timer value, so no match is missed or duplicated while the bench waits for it.

// File: rtl/tgpio_pkg.sv
package tgpio_pkg;
    localparam logic [2:0] ADR_CTRL = 3'd0;
    localparam logic [2:0] ADR_TGT  = 3'd1;
    localparam logic [2:0] ADR_IVL  = 3'd2;
    localparam logic [2:0] ADR_CAP  = 3'd3;
    localparam logic [2:0] ADR_SNAP = 3'd4;

    localparam int B_EN  = 0;
    localparam int B_OUT = 1;
    localparam int B_PER = 2;
    localparam int B_STS = 3;
    localparam int B_OVR = 4;

    typedef struct packed {
        logic ovr;
        logic sts;
        logic per;
        logic omode;
        logic en;
    } ctrl_view_t;
endpackage

// File: rtl/tgpio_in_qual.sv
module tgpio_in_qual #(
    parameter int QUAL = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic ev
);
    localparam int QW = $clog2(QUAL + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [QW-1:0] run;
    } qstate_t;

    qstate_t q_q, q_d;

    always_comb begin
        q_d    = q_q;
        q_d.s1 = pin;
        q_d.s2 = q_q.s1;
        ev     = q_q.s2 && (q_q.run == QW'(QUAL - 1));
        if (!q_q.s2) begin
            q_d.run = '0;
        end else if (q_q.run != QW'(QUAL)) begin
            q_d.run = q_q.run + QW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end
endmodule

// File: rtl/tgpio_pulse.sv
module tgpio_pulse #(
    parameter int PW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    output logic busy
);
    localparam int PCW = $clog2(PW + 1);

    logic [PCW-1:0] left_q, left_d;

    always_comb begin
        left_d = left_q;
        if (clr)                  left_d = '0;
        else if (start)           left_d = PCW'(PW);
        else if (left_q != '0)    left_d = left_q - PCW'(1);
        busy = (left_q != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end
endmodule

// File: rtl/tgpio_stamp.sv
module tgpio_stamp
    import tgpio_pkg::*;
#(
    parameter int TW   = 32,
    parameter int CW   = 16,
    parameter int QUAL = 2,
    parameter int PW   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] timer,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_addr,
    input  logic [TW-1:0] reg_wdata,
    output logic [TW-1:0] reg_rdata,
    input  logic          pin_in,
    output logic          pin_out,
    output logic          pin_oe
);
    typedef struct packed {
        logic          en;
        logic          omode;
        logic          per;
        logic          armed;
        logic [TW-1:0] target;
        logic [TW-1:0] ivl;
        logic [TW-1:0] cap;
        logic [CW-1:0] cnt;
        logic [CW-1:0] snap;
        logic          sts;
        logic          ovr;
    } state_t;

    state_t st_q, st_d;

    logic qual_ev, in_ev, match, ev, rd_cap, busy;
    ctrl_view_t cview;

    tgpio_in_qual #(.QUAL(QUAL)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pin_in),
        .ev    (qual_ev)
    );

    tgpio_pulse #(.PW(PW)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!st_q.en),
        .start (match),
        .busy  (busy)
    );

    always_comb begin
        st_d   = st_q;
        in_ev  = qual_ev && st_q.en && !st_q.omode;
        match  = st_q.en && st_q.omode && st_q.armed && (timer == st_q.target);
        ev     = in_ev || match;
        rd_cap = reg_rd && (reg_addr == ADR_CAP);

        if (rd_cap) begin
            st_d.snap = st_q.cnt;
            st_d.sts  = 1'b0;
        end

        if (match) begin
            if (st_q.per && (st_q.ivl != '0)) st_d.target = st_q.target + st_q.ivl;
            else                               st_d.armed  = 1'b0;
        end

        if (reg_wr) begin
            case (reg_addr)
                ADR_CTRL: begin
                    st_d.en    = reg_wdata[B_EN];
                    st_d.omode = reg_wdata[B_OUT];
                    st_d.per   = reg_wdata[B_PER];
                    if (reg_wdata[B_OVR]) st_d.ovr = 1'b0;
                end
                ADR_TGT: begin
                    st_d.target = reg_wdata;
                    st_d.armed  = 1'b1;
                end
                ADR_IVL: st_d.ivl = reg_wdata;
                default: ;
            endcase
        end

        if (ev) begin
            st_d.cap = timer;
            st_d.cnt = st_q.cnt + CW'(1);
            st_d.sts = 1'b1;
            if (st_q.sts && !rd_cap) st_d.ovr = 1'b1;
        end

        if (!st_q.en) st_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_oe  = st_q.en && st_q.omode;
    assign pin_out = busy && pin_oe;

    always_comb begin
        cview = '{ovr: st_q.ovr, sts: st_q.sts, per: st_q.per,
                  omode: st_q.omode, en: st_q.en};
        case (reg_addr)
            ADR_CTRL: reg_rdata = TW'(cview);
            ADR_TGT:  reg_rdata = st_q.target;
            ADR_IVL:  reg_rdata = st_q.ivl;
            ADR_CAP:  reg_rdata = st_q.cap;
            ADR_SNAP: reg_rdata = TW'(st_q.snap);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tgpio_stamp_chk.sv
module tgpio_stamp_chk
    import tgpio_pkg::*;
#(
    parameter int TW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pin_out,
    input logic          pin_oe,
    input logic          en_q,
    input logic          per_q,
    input logic          ovr_q,
    input logic [CW-1:0] cnt_q,
    input logic [TW-1:0] cap_q,
    input logic [TW-1:0] tgt_q,
    input logic [TW-1:0] ivl_q,
    input logic          ev,
    input logic          match,
    input logic          reg_wr,
    input logic [2:0]    reg_addr,
    input logic [TW-1:0] reg_wdata
);
    logic ovr_clr_wr, tgt_wr;
    assign ovr_clr_wr = reg_wr && (reg_addr == ADR_CTRL) && reg_wdata[B_OVR];
    assign tgt_wr     = reg_wr && (reg_addr == ADR_TGT);

    a_r2_capture_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_q) |-> $past(ev));

    a_r4_pulse_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_out) |=> (pin_out || !pin_oe));

    a_r5_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (match && per_q && (ivl_q != '0) && !tgt_wr) |=> (tgt_q == $past(tgt_q) + $past(ivl_q)));

    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> (!en_q || (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CW'(1))));

    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !ovr_clr_wr) |=> ovr_q);

    a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (cnt_q == '0));
endmodule

bind tgpio_stamp tgpio_stamp_chk #(.TW(TW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .en_q      (st_q.en),
    .per_q     (st_q.per),
    .ovr_q     (st_q.ovr),
    .cnt_q     (st_q.cnt),
    .cap_q     (st_q.cap),
    .tgt_q     (st_q.target),
    .ivl_q     (st_q.ivl),
    .ev        (ev),
    .match     (match),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata)
);

// File: tb/sim_tgpio_stamp.sv
`timescale 1ns/1ps
module sim_tgpio_stamp;
    localparam int TW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] tmr = '0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [TW-1:0] reg_wdata = '0;
    logic [TW-1:0] reg_rdata;
    logic          pin_in = 1'b0;
    logic          pin_out, pin_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) tmr <= tmr + 1;

    tgpio_stamp u0 (
        .clk(clk), .rst_n(rst_n), .timer(tmr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // {expect_event, width in clock edges}
    localparam logic [7:0] VEC [6] = '{8'h01, 8'h82, 8'h83, 8'h01, 8'h85, 8'h82};

    task automatic check(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [TW-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [TW-1:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_tmr(input logic [TW-1:0] v);
        while (tmr != v) @(negedge clk);
    endtask

    task automatic finish_test;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            finish_test();
        end
    end

    initial begin
        logic [TW-1:0] d, t, cap_exp;
        int cnt_exp;
        cap_exp = '0; cnt_exp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_out", TW'(pin_out), '0);
        check("R1 pin_oe", TW'(pin_oe), '0);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            check("R1 register", d, '0);
        end

        // R2 R3 R6 R7: capture mode vector walk
        wr(3'd0, 32'h1);
        for (int i = 0; i < 6; i++) begin
            t = tmr;
            pin_in = 1'b1;
            repeat (int'(VEC[i][3:0])) @(negedge clk);
            pin_in = 1'b0;
            repeat (6) @(negedge clk);
            if (VEC[i][7]) begin
                cap_exp = t + 3;
                cnt_exp++;
            end
            rd(3'd0, d);
            check("R7 status after pulse", d, VEC[i][7] ? 32'h9 : 32'h1);
            rd(3'd3, d);
            check("R2 R3 captured time", d, cap_exp);
            rd(3'd4, d);
            check("R6 counter snapshot", d, TW'(cnt_exp));
        end

        // R8: disabled pin ignored, counter cleared
        wr(3'd0, 32'h0);
        cnt_exp = 0;
        pin_in = 1'b1;
        repeat (4) @(negedge clk);
        pin_in = 1'b0;
        repeat (6) @(negedge clk);
        rd(3'd0, d);
        check("R8 no event while disabled", d, 32'h0);
        rd(3'd3, d);
        check("R8 capture unchanged", d, cap_exp);
        rd(3'd4, d);
        check("R8 counter cleared", d, 32'h0);

        // R4: one-shot generate
        wr(3'd0, 32'h3);
        t = tmr;
        wr(3'd1, t + 20);
        wait_tmr(t + 20);
        check("R4 pin_oe in generate mode", TW'(pin_oe), 32'h1);
        check("R4 pin low before match", TW'(pin_out), '0);
        @(negedge clk);
        check("R4 pulse cycle 1", TW'(pin_out), 32'h1);
        @(negedge clk);
        check("R4 pulse cycle 2", TW'(pin_out), 32'h1);
        @(negedge clk);
        check("R4 pulse ended", TW'(pin_out), '0);
        wait_tmr(t + 35);
        check("R4 one-shot no repeat", TW'(pin_out), '0);
        cnt_exp = 1;
        rd(3'd3, d);
        check("R4 captured match time", d, t + 20);
        rd(3'd4, d);
        check("R6 counter after one match", d, TW'(cnt_exp));
        rd(3'd0, d);
        check("R7 status cleared by capture read", d, 32'h3);

        // R5 R7 R8: periodic, overrun, disable mid-pulse
        wr(3'd2, 32'd10);
        wr(3'd0, 32'h7);
        t = tmr;
        wr(3'd1, t + 20);
        wait_tmr(t + 21);
        check("R5 first periodic pulse", TW'(pin_out), 32'h1);
        wait_tmr(t + 26);
        check("R5 low between pulses", TW'(pin_out), '0);
        wait_tmr(t + 31);
        check("R5 second pulse", TW'(pin_out), 32'h1);
        wait_tmr(t + 41);
        check("R5 third pulse", TW'(pin_out), 32'h1);
        rd(3'd0, d);
        check("R7 overrun set", d, 32'h1F);
        wait_tmr(t + 51);
        check("R5 fourth pulse", TW'(pin_out), 32'h1);
        wr(3'd0, 32'h10);
        check("R8 pulse ends on disable", TW'(pin_out), '0);
        check("R8 pin_oe dropped", TW'(pin_oe), '0);
        rd(3'd0, d);
        check("R7 overrun cleared by write", d, 32'h8);
        rd(3'd3, d);
        check("R5 last capture", d, t + 50);
        rd(3'd4, d);
        check("R8 counter zero after disable", d, 32'h0);

        // R5: interval zero gives a single match
        wr(3'd2, 32'd0);
        wr(3'd0, 32'h7);
        t = tmr;
        wr(3'd1, t + 20);
        wait_tmr(t + 21);
        check("R5 zero-interval pulse", TW'(pin_out), 32'h1);
        wait_tmr(t + 45);
        check("R5 zero-interval no repeat", TW'(pin_out), '0);
        rd(3'd3, d);
        check("R5 zero-interval capture", d, t + 20);
        rd(3'd4, d);
        check("R6 counter one", d, 32'h1);

        finish_test();
    end
endmodule